// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block locates and accesses one 8-byte entry of an in-memory lookup table on behalf of a controller. The caller presents a table descriptor (a physical-address field, a page-size code, an entry-size code and a flat/indirect flag), an identifier, and the operation: read or write. The walker forms the entry address and performs the memory accesses over a request/acknowledge port. In indirect mode it first fetches a pointer entry from the top-level table and goes on to the second level only when that pointer is marked valid.

When the walk ends, the block pulses `done` and updates three result outputs. `rdata` holds the fetched entry. `ent_valid` holds its valid flag, or whether a write landed. `bus_err` shows that one of the accesses failed. Only one memory access is outstanding at a time, and a new walk can be started only while the block is idle.

Top module: `tbl_walker`

## Requirements
- R1: Page-size code `psz` selects the page size used for the walk: 0 selects 4 KB, 1 selects 16 KB, and both 2 and 3 select 64 KB.
- R2: The table base is formed from the 36-bit `pa` field. For 4 KB and 16 KB pages it is `pa << 12`. For 64 KB pages, `pa[35:4]` lands at address bits 47:16 and `pa[3:0]` lands at bits 51:48.
- R3: In flat mode (`ind`=0) exactly one access is made, at base + id × E, where the entry size E is 8 << `esz` bytes.
- R4: In indirect mode the first access is a read at base + 8 × (id / (P / 8)), where P is the page size in bytes.
- R5: A top-level pointer whose bit 63 is clear ends the walk after that single read. `done` is then raised with `ent_valid`=0, `bus_err`=0 and `rdata`=0.
- R6: With a valid pointer, the second access goes to pointer bits [50:0] + E × (id mod (P / E)).
- R7: A completed read returns the entry on `rdata`, and `ent_valid` equals bit 0 of that entry.
- R8: `mem_err` on any acknowledged access ends the walk at once. `done` is raised with `bus_err`=1, `ent_valid`=0 and `rdata`=0, and no further access is made.
- R9: `mem_req` and `mem_addr` stay stable until `mem_ack`. A `start` that arrives while `busy` is high is ignored.
- R10: `done` is a one-cycle pulse, raised in the cycle that `busy` falls. `ent_valid`, `bus_err` and `rdata` change only together with `done`, and they hold their values until then.
- R11: A write (`wr`=1) stores `wdata` at the final entry address with `mem_we`=1 and finishes with `ent_valid`=1 and `rdata`=0. In indirect mode the pointer is read first. If that pointer is invalid, the write is dropped without error and `ent_valid` is 0.
- R12: After reset the block is idle. `busy`, `done`, `mem_req`, `ent_valid`, `bus_err` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted only while idle) |
| wr | input | 1 | 1 = write the entry, 0 = read it |
| ind | input | 1 | 1 = two-level table, 0 = flat table |
| psz | input | 2 | Page-size code |
| esz | input | 2 | Entry-size code, E = 8 << esz bytes |
| pa | input | 36 | Physical-address field of the descriptor |
| id | input | IDW | Identifier to look up |
| wdata | input | 64 | Entry value for writes |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| ent_valid | output | 1 | Entry valid / write performed |
| bus_err | output | 1 | A memory access failed |
| rdata | output | 64 | Entry read |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 52 | Byte address of the access |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed (valid with mem_ack) |
| mem_rdata | input | 64 | Read data (valid with mem_ack) |

## Verification
Flat walks are run across all four entry sizes with both the narrow and the wide base layout. This separates errors in the base formation from errors in the index scaling. Indirect walks are run with every page-size code, including both codes that mean 64 KB. Each is run with valid and invalid pointers, which shows whether the index split point and the early stop are correct. Errors are injected separately on the pointer read, the leaf read and a leaf write, to tell an early abort from a late one. Random walks then mix modes, ids, sizes and memory latency. A start pulse during a busy walk checks that the access sequence is left unchanged.

// File: rtl/tbl_walker.sv
module tbl_walker #(
  parameter int IDW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           wr,
  input  logic           ind,
  input  logic [1:0]     psz,
  input  logic [1:0]     esz,
  input  logic [35:0]    pa,
  input  logic [IDW-1:0] id,
  input  logic [63:0]    wdata,
  output logic           busy,
  output logic           done,
  output logic           ent_valid,
  output logic           bus_err,
  output logic [63:0]    rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [51:0]    mem_addr,
  output logic [63:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  input  logic [63:0]    mem_rdata
);
  localparam int AW = 52;

  typedef enum logic [1:0] {IDLE, LVL1, LEAF} st_t;
  st_t st;

  logic          op_wr;
  logic [4:0]    pg_lg;
  logic [2:0]    es_lg;
  logic [AW-1:0] base_q, leaf_q, id_q;
  logic [63:0]   wd_q;

  logic [4:0]    pg_lg_in;
  logic [2:0]    es_lg_in;
  logic [AW-1:0] base_in, id_in, l1_addr, l2_off, l2_mask;

  assign pg_lg_in = (psz == 2'd0) ? 5'd12 : (psz == 2'd1) ? 5'd14 : 5'd16;
  assign es_lg_in = 3'(esz) + 3'd3;
  assign base_in  = psz[1] ? {pa[3:0], pa[35:4], 16'b0} : {4'b0, pa, 12'b0};
  assign id_in    = AW'(id);

  assign l1_addr  = base_q + ((id_q >> (pg_lg - 5'd3)) << 3);
  assign l2_mask  = (AW'(1) << (pg_lg - 5'(es_lg))) - AW'(1);
  assign l2_off   = (id_q & l2_mask) << es_lg;

  assign busy      = (st != IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st == LEAF) && op_wr;
  assign mem_addr  = (st == LVL1) ? l1_addr : leaf_q;
  assign mem_wdata = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      op_wr     <= 1'b0;
      pg_lg     <= 5'd12;
      es_lg     <= 3'd3;
      base_q    <= '0;
      leaf_q    <= '0;
      id_q      <= '0;
      wd_q      <= '0;
      done      <= 1'b0;
      ent_valid <= 1'b0;
      bus_err   <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          op_wr  <= wr;
          pg_lg  <= pg_lg_in;
          es_lg  <= es_lg_in;
          base_q <= base_in;
          id_q   <= id_in;
          wd_q   <= wdata;
          leaf_q <= base_in + (id_in << es_lg_in);
          st     <= ind ? LVL1 : LEAF;
        end
        LVL1: if (mem_ack) begin
          if (mem_err || !mem_rdata[63]) begin
            st        <= IDLE;
            done      <= 1'b1;
            bus_err   <= mem_err;
            ent_valid <= 1'b0;
            rdata     <= '0;
          end else begin
            leaf_q <= AW'(mem_rdata[50:0]) + l2_off;
            st     <= LEAF;
          end
        end
        LEAF: if (mem_ack) begin
          st        <= IDLE;
          done      <= 1'b1;
          bus_err   <= mem_err;
          ent_valid <= !mem_err && (op_wr || mem_rdata[0]);
          rdata     <= (mem_err || op_wr) ? 64'd0 : mem_rdata;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tbl_walker_chk.sv
module tbl_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        ent_valid,
  input logic        bus_err,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [51:0] mem_addr
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);  // R10
  AST_FLAGS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bus_err) || !$stable(ent_valid)) |-> done);  // R10
  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bus_err) |-> !ent_valid);  // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));  // R9
endmodule

bind tbl_walker tbl_walker_chk u_chk (.*);

// File: tb/tbl_walker_test.sv
module tbl_walker_test;
  logic clk = 0, rst_n = 0;
  logic start = 0, wr = 0, ind = 0;
  logic [1:0] psz = 0, esz = 0;
  logic [35:0] pa = 0;
  logic [23:0] id = 0;
  logic [63:0] wdata = 0;
  logic busy, done, ent_valid, bus_err, mem_req, mem_we;
  logic [63:0] rdata, mem_wdata;
  logic [51:0] mem_addr;
  logic mem_ack = 0, mem_err = 0;
  logic [63:0] mem_rdata = 0;

  always #4 clk = ~clk;

  tbl_walker #(.IDW(24)) uut (.*);

  logic [63:0] mem [logic [51:0]];
  int checks = 0, errs = 0, lat = 0, acc_n = 0;
  logic [51:0] acc_a [4];
  logic acc_w [4];
  bit err_on = 0;
  logic [51:0] err_a = 0;

  function automatic logic [63:0] rd(logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction
  function automatic longint pgb(logic [1:0] p);
    return (p == 0) ? 4096 : (p == 1) ? 16384 : 65536;
  endfunction
  function automatic longint esb(logic [1:0] e);
    return longint'(8) << e;
  endfunction
  function automatic logic [51:0] ebase(logic [1:0] p, logic [35:0] a);
    if (p >= 2) return (52'(a[35:4]) << 16) | (52'(a[3:0]) << 48);
    return 52'(a) << 12;
  endfunction
  function automatic logic [51:0] eflat(logic [1:0] p, logic [1:0] e, logic [35:0] a, logic [23:0] i);
    return ebase(p, a) + 52'(longint'(i) * esb(e));
  endfunction
  function automatic logic [51:0] el1(logic [1:0] p, logic [35:0] a, logic [23:0] i);
    return ebase(p, a) + 52'((longint'(i) / (pgb(p) / 8)) * 8);
  endfunction
  function automatic logic [51:0] eleaf(logic [1:0] p, logic [1:0] e, logic [63:0] l1e, logic [23:0] i);
    return 52'(l1e[50:0]) + 52'((longint'(i) % (pgb(p) / esb(e))) * esb(e));
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0; mem_err = 0;
    end else if (mem_req) begin
      if (lat > 0) lat--;
      else begin
        if (acc_n < 4) begin acc_a[acc_n] = mem_addr; acc_w[acc_n] = mem_we; end
        acc_n++;
        if (err_on && mem_addr == err_a) begin
          mem_err = 1; mem_rdata = 64'hBAD0_BAD0_BAD0_BAD0;
        end else begin
          if (mem_we) mem[mem_addr] = mem_wdata;
          mem_rdata = rd(mem_addr); mem_err = 0;
        end
        mem_ack = 1;
        lat = $urandom % 3;
      end
    end
  end

  task automatic setup_ind(logic [1:0] p, logic [1:0] e, logic [35:0] a, logic [23:0] i,
                           bit v, logic [50:0] l2b, logic [63:0] leafv);
    logic [63:0] l1e;
    l1e = {v, 12'd0, l2b[50:3], 3'd0};
    mem[el1(p, a, i)] = l1e;
    mem[eleaf(p, e, l1e, i)] = leafv;
  endtask

  task automatic walk(bit i_ind, logic [1:0] p, logic [1:0] e, logic [35:0] a,
                      logic [23:0] iv, bit w, logic [63:0] wd, bit poke);
    logic [51:0] ea [2];
    bit ew [2];
    int en = 0;
    bit eerr = 0, eval = 0, go = 1;
    logic [63:0] erd = 0, l1e;
    logic [51:0] lf;
    if (i_ind) begin
      ea[0] = el1(p, a, iv); ew[0] = 0; en = 1;
      if (err_on && ea[0] == err_a) begin eerr = 1; go = 0; end
      else begin
        l1e = rd(ea[0]);
        if (!l1e[63]) go = 0;
        lf = eleaf(p, e, l1e, iv);
      end
    end else lf = eflat(p, e, a, iv);
    if (go) begin
      ea[en] = lf; ew[en] = w; en++;
      if (err_on && lf == err_a) eerr = 1;
      else if (w) eval = 1;
      else begin erd = rd(lf); eval = erd[0]; end
    end
    @(negedge clk);
    acc_n = 0;
    ind = i_ind; psz = p; esz = e; pa = a; id = iv; wr = w; wdata = wd; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      chk("R9 busy during walk", 64'(busy), 64'd1);
      start = 1; id = iv ^ 24'h1; ind = !i_ind; wr = !w;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    chk(i_ind ? "R8/R5 err" : "R8 err", 64'(bus_err), 64'(eerr));
    chk(w ? "R11 ent_valid" : "R7 ent_valid", 64'(ent_valid), 64'(eval));
    chk(w ? "R11 rdata" : "R7 rdata", rdata, erd);
    chk(i_ind ? "R5 R6 access count" : "R3 access count", 64'(acc_n), 64'(en));
    if (acc_n == en) begin
      for (int k = 0; k < en; k++) begin
        if (i_ind && k == 0) chk("R1 R2 R4 level-1 address", 64'(acc_a[k]), 64'(ea[k]));
        else if (i_ind) chk("R1 R6 leaf address", 64'(acc_a[k]), 64'(ea[k]));
        else chk("R2 R3 flat address", 64'(acc_a[k]), 64'(ea[k]));
        chk("R11 write enable", 64'(acc_w[k]), 64'(ew[k]));
      end
    end
    @(negedge clk);
    chk("R10 done one cycle", 64'(done), 64'd0);
    if (poke) chk("R9 start ignored while busy", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [23:0] iv;
    logic [35:0] a;
    logic [1:0] p, e;
    bit im, w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R12 busy", 64'(busy), 0);
    chk("R12 done", 64'(done), 0);
    chk("R12 mem_req", 64'(mem_req), 0);
    chk("R12 ent_valid", 64'(ent_valid), 0);
    chk("R12 bus_err", 64'(bus_err), 0);
    chk("R12 rdata", rdata, 0);
    rst_n = 1;
    // R3 R2: flat, every entry size, narrow and wide base layouts
    for (int pp = 0; pp < 4; pp++)
      for (int ee = 0; ee < 4; ee++) begin
        a = 36'hA_5C3_1F0_7 + 36'(pp * 17 + ee);
        iv = 24'h000135 + 24'(ee * 3);
        mem[eflat(2'(pp), 2'(ee), a, iv)] = {60'h1234_5678_9ABC_DEF, 3'b000, ee[0]};
        walk(0, 2'(pp), 2'(ee), a, iv, 0, 0, 0);
      end
    // R1 R4 R6: indirect, every page code, valid pointer
    for (int pp = 0; pp < 4; pp++) begin
      iv = 24'h0ABCDE;
      setup_ind(2'(pp), 2'(pp), 36'h3_0000_0011, iv, 1, 51'h0_1234_5678_9000, 64'hFEED_0000_0000_0001);
      walk(1, 2'(pp), 2'(pp), 36'h3_0000_0011, iv, 0, 0, 0);
    end
    // R5: invalid pointer, read and write
    setup_ind(0, 1, 36'h7_7777_7000, 24'h4242, 0, 51'h4000_0000, 64'h1);
    walk(1, 0, 1, 36'h7_7777_7000, 24'h4242, 0, 0, 0);
    walk(1, 0, 1, 36'h7_7777_7000, 24'h4242, 1, 64'hCAFE, 0);
    // R8: error on pointer read, leaf read, flat leaf write
    setup_ind(1, 0, 36'h1_2000_0000, 24'h77, 1, 51'h8_0000_0000, 64'h3);
    err_on = 1; err_a = el1(1, 36'h1_2000_0000, 24'h77);
    walk(1, 1, 0, 36'h1_2000_0000, 24'h77, 0, 0, 0);
    err_a = eleaf(1, 0, rd(el1(1, 36'h1_2000_0000, 24'h77)), 24'h77);
    walk(1, 1, 0, 36'h1_2000_0000, 24'h77, 0, 0, 0);
    err_a = eflat(2, 3, 36'h0_0000_0042, 24'h9);
    walk(0, 2, 3, 36'h0_0000_0042, 24'h9, 1, 64'h55, 0);
    chk("R8 failed write leaves memory", rd(err_a), 64'd0);
    err_on = 0;
    // R11: writes then read back
    walk(0, 1, 2, 36'h0_0001_0000, 24'h321, 1, 64'h0123_4567_89AB_CDEF, 0);
    walk(0, 1, 2, 36'h0_0001_0000, 24'h321, 0, 0, 0);
    setup_ind(3, 3, 36'h0_F000_0000, 24'hFFFF, 1, 51'h2_0000_0000, 64'h0);
    walk(1, 3, 3, 36'h0_F000_0000, 24'hFFFF, 1, 64'hABCD_0000_0000_0011, 0);
    walk(1, 3, 3, 36'h0_F000_0000, 24'hFFFF, 0, 0, 0);
    // R9: start while busy
    walk(1, 3, 3, 36'h0_F000_0000, 24'hFFFF, 0, 0, 1);
    walk(0, 1, 2, 36'h0_0001_0000, 24'h321, 0, 0, 1);
    // random mix
    for (int n = 0; n < 200; n++) begin
      im = 1'($urandom); w = 1'($urandom);
      p = 2'($urandom); e = 2'($urandom);
      a = {4'($urandom), 32'($urandom)};
      iv = 24'($urandom);
      if (im) setup_ind(p, e, a, iv, ($urandom % 4) != 0,
                        {19'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)});
      else mem[eflat(p, e, a, iv)] = {32'($urandom), 32'($urandom)};
      err_on = ($urandom % 8) == 0;
      if (err_on) err_a = (im && ($urandom % 2 == 0)) ? el1(p, a, iv)
                        : im ? eleaf(p, e, rd(el1(p, a, iv)), iv) : eflat(p, e, a, iv);
      walk(im, p, e, a, iv, w, {32'($urandom), 32'($urandom)}, ($urandom % 10) == 0);
      err_on = 0;
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule